// File: doc/BRIEF.md
# Three-Byte-Instruction Single-Cycle Core

This block is a small processor core that completes one instruction on every clock edge. Each instruction is 24 bits wide and occupies three consecutive bytes of a byte-addressed instruction store, so the program counter normally moves forward by three. The core holds sixteen 16-bit general registers. Register 0 is fixed at zero.

The core decodes three instruction layouts. Register-register operations use a function field. Immediate operations, branches and memory accesses carry a signed 12-bit constant. Jumps carry a full 16-bit byte address. A combinational control unit derives the register write enable, the memory enables, the operand and destination selects, a 3-bit ALU operation and a 2-bit next-PC source from the opcode and function fields.

Both the instruction store and the word-wide data store are internal arrays. The instruction store is loaded from outside the core before reset is released. The only outputs are the current PC and a read port that shows the value of any one register.

Top module: `tri_byte_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next value of `pc` is 0 and every register reads 0 afterwards.
- R2: Every instruction that is not a taken branch, `j` or `jr` advances `pc` by 3. Instruction bits [23:16] come from byte `pc`, bits [15:8] from `pc+1` and bits [7:0] from `pc+2`.
- R3: Opcode 0 is register-register: opcode [23:20], Rs [19:16], Rt [15:12], Rd [11:8], function [3:0]. Function 0 writes Rs+Rt into Rd, 1 writes Rs-Rt, 2 writes Rs AND Rt, 3 writes Rs OR Rt, and 4 writes 1 if Rs is less than Rt as signed numbers and 0 otherwise. Any other function value changes no register.
- R4: Opcodes 1 (add), 2 (subtract), 3 (AND) and 4 (OR) write Rt with Rs combined with the immediate [11:0], which is sign-extended to 16 bits.
- R5: Opcode 5 (equal) and opcode 6 (not equal) compare Rs with Rt. When taken, the next `pc` is (pc+3) + 3 × sign-extended immediate, modulo 2^16; otherwise it is pc+3.
- R6: Opcode 8 loads bits [15:0] of the instruction into `pc` unchanged.
- R7: Opcode 7 loads the value of register Rs into `pc`.
- R8: Opcode 9 writes Rt with the data word at Rs + sign-extended immediate, and opcode 10 stores Rt at that address. The word index is the low log2(DMEM_WORDS) bits of the address.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: Opcodes 11 to 15 change no register and no data word, and they advance `pc` by 3.
- R11: `dbg_rdata` shows, without a clock delay, the current value of the register selected by `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_addr | input | 4 | Register selected for observation |
| dbg_rdata | output | 16 | Current value of the selected register |
| pc | output | 16 | Byte address of the instruction now executing |

## Verification
Because every instruction completes in one cycle, a fault in decode, in the ALU or in next-PC selection shows up on the ports one edge after the faulty instruction. A wrong target or step size appears at once on `pc`. A wrong result appears on `dbg_rdata` when the destination register is scanned. A store to the wrong address is visible only later, when a load brings the word back into a register. For that reason the program loads back every address it has stored to.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int XW   = 16;  // register and data width
  localparam int IW   = 24;  // instruction width
  localparam int RA_W = 4;   // register address width
  localparam int NREG = 1 << RA_W;
  localparam int IMMW = 12;
  localparam int ILEN = IW / 8;  // bytes per instruction

  localparam logic [3:0] OP_RTYPE = 4'd0;
  localparam logic [3:0] OP_ADDI  = 4'd1;
  localparam logic [3:0] OP_SUBI  = 4'd2;
  localparam logic [3:0] OP_ANDI  = 4'd3;
  localparam logic [3:0] OP_ORI   = 4'd4;
  localparam logic [3:0] OP_BEQ   = 4'd5;
  localparam logic [3:0] OP_BNE   = 4'd6;
  localparam logic [3:0] OP_JR    = 4'd7;
  localparam logic [3:0] OP_J     = 4'd8;
  localparam logic [3:0] OP_LOAD  = 4'd9;
  localparam logic [3:0] OP_STORE = 4'd10;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {PC_SEQ, PC_BRANCH, PC_JUMP, PC_REG} pc_sel_e;

  typedef struct packed {
    logic    rf_wen;
    logic    dst_rt;
    logic    alu_imm;
    alu_op_e alu_op;
    logic    mem_re;
    logic    mem_we;
    logic    br_on_eq;
    logic    br_on_ne;
    logic    is_jump;
    logic    is_jr;
  } ctrl_t;

  function automatic logic [XW-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(XW-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [XW-1:0] seq_pc(input logic [XW-1:0] cur);
    return cur + XW'(ILEN);
  endfunction

  // offset counts instructions: scale by three as (x<<1)+x
  function automatic logic [XW-1:0] branch_pc(input logic [XW-1:0] nxt,
                                              input logic [XW-1:0] off);
    return nxt + (off << 1) + off;
  endfunction
endpackage

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic [3:0] funct,
  output ctrl_t      c
);
  always_comb begin
    c        = '0;
    c.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          4'd0: begin c.rf_wen = 1'b1; c.alu_op = ALU_ADD; end
          4'd1: begin c.rf_wen = 1'b1; c.alu_op = ALU_SUB; end
          4'd2: begin c.rf_wen = 1'b1; c.alu_op = ALU_AND; end
          4'd3: begin c.rf_wen = 1'b1; c.alu_op = ALU_OR;  end
          4'd4: begin c.rf_wen = 1'b1; c.alu_op = ALU_SLT; end
          default: c.rf_wen = 1'b0;
        endcase
      end
      OP_ADDI:  begin c.rf_wen = 1'b1; c.dst_rt = 1'b1; c.alu_imm = 1'b1; c.alu_op = ALU_ADD; end
      OP_SUBI:  begin c.rf_wen = 1'b1; c.dst_rt = 1'b1; c.alu_imm = 1'b1; c.alu_op = ALU_SUB; end
      OP_ANDI:  begin c.rf_wen = 1'b1; c.dst_rt = 1'b1; c.alu_imm = 1'b1; c.alu_op = ALU_AND; end
      OP_ORI:   begin c.rf_wen = 1'b1; c.dst_rt = 1'b1; c.alu_imm = 1'b1; c.alu_op = ALU_OR;  end
      OP_BEQ:   begin c.br_on_eq = 1'b1; c.alu_op = ALU_SUB; end
      OP_BNE:   begin c.br_on_ne = 1'b1; c.alu_op = ALU_SUB; end
      OP_JR:    c.is_jr = 1'b1;
      OP_J:     c.is_jump = 1'b1;
      OP_LOAD:  begin c.rf_wen = 1'b1; c.dst_rt = 1'b1; c.alu_imm = 1'b1; c.mem_re = 1'b1; end
      OP_STORE: begin c.alu_imm = 1'b1; c.mem_we = 1'b1; end
      default:  c.rf_wen = 1'b0;
    endcase
  end
endmodule

// File: rtl/tbc_regfile.sv
module tbc_regfile
  import tbc_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][RA_W-1:0]  raddr,
  output logic [NRD-1:0][XW-1:0]    rdata,
  input  logic                      wen,
  input  logic [RA_W-1:0]           waddr,
  input  logic [XW-1:0]             wdata
);
  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wen && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/tbc_alu.sv
module tbc_alu
  import tbc_pkg::*;
(
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y,
  output logic          zero
);
  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XW-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/tri_byte_core.sv
module tri_byte_core
  import tbc_pkg::*;
#(
  parameter int IMEM_BYTES = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] dbg_addr,
  output logic [XW-1:0]   dbg_rdata,
  output logic [XW-1:0]   pc
);
  localparam int IA_W = $clog2(IMEM_BYTES);
  localparam int DA_W = $clog2(DMEM_WORDS);

  // instruction bytes, loaded from outside before reset is released
  logic [7:0]    imem [IMEM_BYTES];
  logic [XW-1:0] dmem [DMEM_WORDS];

  // fetch, most significant byte first
  logic [IA_W-1:0] ia0, ia1, ia2;
  logic [IW-1:0]   instr;
  assign ia0   = pc[IA_W-1:0];
  assign ia1   = ia0 + 1'b1;
  assign ia2   = ia0 + 2'd2;
  assign instr = {imem[ia0], imem[ia1], imem[ia2]};

  logic [3:0]      opcode, funct;
  logic [RA_W-1:0] rs_a, rt_a, rd_a;
  logic [XW-1:0]   simm;
  assign opcode = instr[23:20];
  assign rs_a   = instr[19:16];
  assign rt_a   = instr[15:12];
  assign rd_a   = instr[11:8];
  assign funct  = instr[3:0];
  assign simm   = sext_imm(instr[IMMW-1:0]);

  ctrl_t c;
  tbc_ctrl u_ctrl (.opcode(opcode), .funct(funct), .c(c));

  // register file: port 0 = Rs, 1 = Rt, 2 = debug
  logic [2:0][XW-1:0] rd_bus;
  logic [XW-1:0]      rs_val, rt_val, wb_data;
  logic [RA_W-1:0]    rf_waddr;
  logic               ev_rf_write, ev_mem_store;

  tbc_regfile #(.NRD(3)) u_rf (
    .clk(clk), .rst(rst),
    .raddr({dbg_addr, rt_a, rs_a}),
    .rdata(rd_bus),
    .wen(ev_rf_write), .waddr(rf_waddr), .wdata(wb_data)
  );
  assign rs_val    = rd_bus[0];
  assign rt_val    = rd_bus[1];
  assign dbg_rdata = rd_bus[2];

  // execute
  logic [XW-1:0] alu_b, alu_y;
  logic          alu_zero;
  assign alu_b = c.alu_imm ? simm : rt_val;
  tbc_alu u_alu (.op(c.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

  // data memory
  logic [DA_W-1:0] d_idx;
  logic [XW-1:0]   mem_rdata;
  assign d_idx        = alu_y[DA_W-1:0];
  assign mem_rdata    = dmem[d_idx];
  assign ev_mem_store = c.mem_we & ~rst;

  always_ff @(posedge clk) begin
    if (ev_mem_store) dmem[d_idx] <= rt_val;
  end

  // write-back
  assign rf_waddr    = c.dst_rt ? rt_a : rd_a;
  assign wb_data     = c.mem_re ? mem_rdata : alu_y;
  assign ev_rf_write = c.rf_wen;

  // next PC
  pc_sel_e       pc_sel;
  logic [XW-1:0] pc_seq, pc_next;
  logic          ev_seq, ev_jump;
  assign pc_seq = seq_pc(pc);

  always_comb begin
    if (c.is_jump)                                              pc_sel = PC_JUMP;
    else if (c.is_jr)                                           pc_sel = PC_REG;
    else if ((c.br_on_eq & alu_zero) | (c.br_on_ne & ~alu_zero)) pc_sel = PC_BRANCH;
    else                                                        pc_sel = PC_SEQ;
  end

  always_comb begin
    case (pc_sel)
      PC_JUMP:   pc_next = instr[15:0];
      PC_REG:    pc_next = rs_val;
      PC_BRANCH: pc_next = branch_pc(pc_seq, simm);
      default:   pc_next = pc_seq;
    endcase
  end

  assign ev_seq  = (pc_sel == PC_SEQ);
  assign ev_jump = (pc_sel == PC_JUMP);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end
endmodule

// File: rtl/tri_byte_core_chk.sv
module tri_byte_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] pc,
  input logic [3:0]  dbg_addr,
  input logic [15:0] dbg_rdata,
  input logic [3:0]  opcode,
  input logic [15:0] jump_tgt,
  input logic        ev_seq,
  input logic        ev_jump,
  input logic        ev_rf_write,
  input logic        ev_mem_store
);
  // R1
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 16'd0);

  // R2
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    ev_seq |=> pc == $past(pc) + 16'd3);

  // R6
  a_r6_direct_jump: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> pc == $past(jump_tgt));

  // R9
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    dbg_addr == 4'd0 |-> dbg_rdata == 16'd0);

  // R8
  a_r8_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    ev_mem_store |-> !ev_rf_write);

  // R10
  a_r10_undef_inert: assert property (@(posedge clk) disable iff (rst)
    opcode >= 4'd11 |-> (!ev_rf_write && !ev_mem_store && ev_seq));
endmodule

bind tri_byte_core tri_byte_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata),
  .opcode(instr[23:20]), .jump_tgt(instr[15:0]),
  .ev_seq(ev_seq), .ev_jump(ev_jump),
  .ev_rf_write(ev_rf_write), .ev_mem_store(ev_mem_store)
);

// File: tb/tri_byte_core_tb.sv
`timescale 1ns/1ps
module tri_byte_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dbg_addr = 4'd0;
  logic [15:0] dbg_rdata, pc;

  always #2 clk = ~clk;  // 250 MHz

  tri_byte_core u_dut (.clk(clk), .rst(rst), .dbg_addr(dbg_addr),
                       .dbg_rdata(dbg_rdata), .pc(pc));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  prog [256];
  logic [15:0] m_reg [16];
  logic [15:0] m_mem [64];
  logic [15:0] m_pc;
  string       pc_tag, reg_tag;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (pc model %h)", tag, act, exp, m_pc);
    end
  endtask

  function automatic logic [23:0] enc_r(input int f, input int rs, input int rt, input int rd);
    return {4'd0, 4'(rs), 4'(rt), 4'(rd), 4'd0, 4'(f)};
  endfunction
  function automatic logic [23:0] enc_i(input int op, input int rs, input int rt, input logic [11:0] imm);
    return {4'(op), 4'(rs), 4'(rt), imm};
  endfunction
  function automatic logic [23:0] enc_j(input logic [15:0] tgt);
    return {4'd8, 4'd0, tgt};
  endfunction

  task automatic put(input int idx, input logic [23:0] w);
    prog[3*idx]   = w[23:16];
    prog[3*idx+1] = w[15:8];
    prog[3*idx+2] = w[7:0];
  endtask

  // behavioural reference: one instruction per rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_pc = 16'd0;
      for (int i = 0; i < 16; i++) m_reg[i] = 16'd0;
      pc_tag = "R1"; reg_tag = "R1";
    end else begin
      logic [23:0] ins;
      logic [15:0] a, b, im, nxt, val, addr;
      int op, dst;
      bit wr;
      ins = {prog[m_pc[7:0]], prog[8'(m_pc[7:0] + 1)], prog[8'(m_pc[7:0] + 2)]};
      op  = int'(ins[23:20]);
      a   = m_reg[ins[19:16]];
      b   = m_reg[ins[15:12]];
      im  = {{4{ins[11]}}, ins[11:0]};
      nxt = m_pc + 16'd3;
      wr  = 0; dst = int'(ins[15:12]); val = 16'd0;
      addr = a + im;
      pc_tag = "R2";
      case (op)
        0: begin
          reg_tag = "R3"; dst = int'(ins[11:8]); wr = 1;
          case (int'(ins[3:0]))
            0: val = a + b;
            1: val = a - b;
            2: val = a & b;
            3: val = a | b;
            4: val = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            default: wr = 0;
          endcase
        end
        1: begin reg_tag = "R4"; wr = 1; val = a + im; end
        2: begin reg_tag = "R4"; wr = 1; val = a - im; end
        3: begin reg_tag = "R4"; wr = 1; val = a & im; end
        4: begin reg_tag = "R4"; wr = 1; val = a | im; end
        5, 6: begin
          reg_tag = "R5"; pc_tag = "R5";
          if ((op == 5) == (a == b)) nxt = nxt + 16'(3 * im);
        end
        7: begin reg_tag = "R7"; pc_tag = "R7"; nxt = a; end
        8: begin reg_tag = "R6"; pc_tag = "R6"; nxt = ins[15:0]; end
        9: begin reg_tag = "R8"; wr = 1; val = m_mem[addr[5:0]]; end
        10: begin reg_tag = "R8"; m_mem[addr[5:0]] = b; end
        default: reg_tag = "R10";
      endcase
      if (wr && dst == 0) reg_tag = "R9";
      if (wr && dst != 0) m_reg[dst] = val;
      m_pc = nxt;
    end
  end

  // compare away from the active edge: PC and every register via the read port (R11)
  always @(negedge clk) begin
    if (!done) begin
      check({pc_tag, " pc"}, pc, m_pc);
      for (int k = 0; k < 16; k++) begin
        dbg_addr = 4'(k);
        #0.05;
        check({reg_tag, "/R11 reg"}, dbg_rdata, m_reg[k]);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    put(0,  enc_i(1, 0, 1, 12'd5));        // r1 = 5
    put(1,  enc_i(1, 0, 2, 12'hFFD));      // r2 = -3
    put(2,  enc_r(0, 1, 2, 3));            // add
    put(3,  enc_r(1, 2, 1, 4));            // sub
    put(4,  enc_r(2, 1, 2, 5));            // and
    put(5,  enc_r(3, 1, 2, 6));            // or
    put(6,  enc_r(4, 2, 1, 7));            // slt true (signed)
    put(7,  enc_r(4, 1, 2, 8));            // slt false
    put(8,  enc_r(7, 1, 1, 9));            // unused function: no write
    put(9,  enc_i(1, 1, 0, 12'd7));        // write to r0 dropped (R9)
    put(10, enc_i(2, 1, 9, 12'd100));      // subi
    put(11, enc_i(3, 6, 10, 12'h0F0));     // andi
    put(12, enc_i(4, 1, 11, 12'h800));     // ori, negative immediate
    put(13, enc_i(10, 1, 4, 12'd2));       // store r4 -> [7]
    put(14, enc_i(10, 0, 11, 12'hFFF));    // store r11 -> [-1], wraps to 63
    put(15, enc_i(9, 1, 12, 12'd2));       // load r12
    put(16, enc_i(9, 2, 13, 12'd2));       // load r13 from 0xFFFF
    put(17, 24'hB12345);                   // undefined opcode 11
    put(18, 24'hF6789A);                   // undefined opcode 15
    put(19, enc_i(1, 0, 14, 12'd3));       // loop counter
    put(20, enc_i(2, 14, 14, 12'd1));
    put(21, enc_i(6, 14, 0, 12'hFFE));     // bne back one instruction
    put(22, enc_i(5, 14, 1, 12'd5));       // beq not taken
    put(23, enc_i(5, 14, 0, 12'd2));       // beq taken to 26
    put(24, enc_i(1, 0, 15, 12'd99));
    put(25, enc_i(1, 0, 15, 12'd98));
    put(26, enc_j(16'd90));                // jump to 30
    put(27, enc_i(1, 0, 15, 12'd1));
    put(28, enc_i(1, 0, 15, 12'd2));
    put(29, enc_i(1, 0, 15, 12'd3));
    put(30, enc_i(1, 0, 15, 12'd99));      // r15 = byte address of 33
    put(31, enc_i(7, 15, 0, 12'd0));       // jr r15
    put(32, enc_i(1, 0, 1, 12'd1));
    put(33, enc_i(1, 0, 3, 12'h7FF));
    put(34, enc_j(16'd102));               // self loop
    for (int i = 0; i < 256; i++) u_dut.imem[i] = prog[i];

    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;                            // R1 again mid-run
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule